// File: doc/BRIEF.md
# Vector Lane Insert Unit

This block carries out a single "insert scalar into vector lane" operation against a register file of 128-bit vector entries. A 5-bit immediate encodes both the element width and the lane number. The position of the lowest set bit among its low four bits picks a width of 8, 16, 32 or 64 bits. The bits above that position give the lane index. The low element-width bits of a scalar register are written into that lane, and every other bit of the destination entry is left exactly as it was.

Each operation is a fixed two-step read-modify-write. In the first step, after a request is accepted, the unit reads the destination vector entry and the scalar source through an external scalar read port. In the second step it writes the merged entry back and pulses `done`. Scalar source index 31 reads as zero. An immediate whose low four bits are all zero is reserved: it raises `undef` together with `done` and changes nothing.

A load port and a combinational inspection port on the vector file let the surrounding environment seed entries and observe results.

Top module: `vec_insert_unit`

## Requirements
- R1: When `reqImm[3:0]` is 4'b0000, the operation completes with `undef` high in the same cycle as `done`, and no vector entry changes.
- R2: The element width is 8 << s, where s is the position of the lowest set bit of `reqImm[3:0]`: xxxx1 gives 8, xxx10 gives 16, xx100 gives 32 and x1000 gives 64 bits.
- R3: The lane index is the unsigned value of `reqImm[4:s+1]`. Lane k of width w occupies bits k*w+w-1 down to k*w, so byte lane k is bits 8k+7:8k. This gives 16, 8, 4 or 2 lanes.
- R4: Every bit of the destination entry outside the selected lane keeps its previous value, and no other entry changes.
- R5: The selected lane receives the low w bits of `sclData`, read at the index that `sclAddr` presents (the request's source index).
- R6: Source index 31 supplies zero, whatever value `sclData` carries.
- R7: `done` is high for exactly one cycle, two clock edges after the edge that accepts `reqValid`, for every encoding and operand value. It is low after reset, and the merged entry is visible on the inspection port from the following edge.
- R8: `reqValid` is ignored while an operation is in progress. The operation in flight completes with its own operands.
- R9: A load strobe writes `loadData` into entry `loadAddr` on the clock edge, and `dbgData` shows entry `dbgAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqImm | input | 5 | Width/lane immediate |
| reqDst | input | 5 | Destination vector entry |
| reqSrc | input | 5 | Scalar source index |
| sclAddr | output | 5 | Scalar read port address |
| sclData | input | 64 | Scalar read port data |
| loadEn | input | 1 | Vector file load strobe |
| loadAddr | input | 5 | Vector file load address |
| loadData | input | 128 | Vector file load data |
| dbgAddr | input | 5 | Inspection read address |
| dbgData | output | 128 | Inspection read data |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Reserved encoding flag, valid with done |

## Verification
The assertions assume three things about the inputs. The scalar port returns stable data while an operation is in flight. No load strobe arrives between acceptance and `done`. Nothing but the unit itself writes the destination entry during that window. The directed stimulus meets these assumptions by seeding entries only while the unit is idle and holding the scalar model constant during each operation. The only overlap it creates on purpose is a second request raised while busy, which the unit must ignore.

// File: rtl/vins_pkg.sv
package vins_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } vinsState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture request operands
    logic readOps;   // read destination and scalar source
    logic finish;    // final cycle of an operation
    logic commit;    // write merged entry back
  } ctrlStrobes_t;

  typedef struct packed {
    logic [1:0] sizeCode;
    logic [3:0] laneIdx;
  } decodeInfo_t;

endpackage

// File: rtl/vins_ctrl.sv
module vins_ctrl
  import vins_pkg::*;
#(
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IMM_W-1:0] reqImm,
  output ctrlStrobes_t     strobes,
  output decodeInfo_t      decInfo,
  output logic             done,
  output logic             undef
);

  vinsState_t       state;
  vinsState_t       stateNext;
  logic [IMM_W-1:0] immQ;
  logic             accept;
  logic             reserved;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      immQ  <= '0;
    end else begin
      state <= stateNext;
      if (accept) immQ <= reqImm;
    end
  end

  // Width comes from the lowest set bit of the low nibble
  always_comb begin
    reserved         = 1'b0;
    decInfo.sizeCode = 2'd0;
    casez (immQ[3:0])
      4'b???1: decInfo.sizeCode = 2'd0;
      4'b??10: decInfo.sizeCode = 2'd1;
      4'b?100: decInfo.sizeCode = 2'd2;
      4'b1000: decInfo.sizeCode = 2'd3;
      default: reserved = 1'b1;
    endcase
    decInfo.laneIdx = immQ[4:1] >> decInfo.sizeCode;
  end

  assign strobes.latchReq = accept;
  assign strobes.readOps  = (state == ST_READ);
  assign strobes.finish   = (state == ST_WRITE);
  assign strobes.commit   = (state == ST_WRITE) && !reserved;

  assign done  = strobes.finish;
  assign undef = strobes.finish && reserved;

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> ##2 done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_UNDEF_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> done); // R1
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && state != ST_IDLE) |=> $stable(immQ)); // R8

endmodule

// File: rtl/vins_datapath.sv
module vins_datapath
  import vins_pkg::*;
#(
  parameter int NUM_VREGS = 32,
  parameter int VREG_W    = 128,
  parameter int SREG_W    = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  decodeInfo_t                  decInfo,
  input  logic [$clog2(NUM_VREGS)-1:0] reqDst,
  input  logic [$clog2(NUM_VREGS)-1:0] reqSrc,
  output logic [$clog2(NUM_VREGS)-1:0] sclAddr,
  input  logic [SREG_W-1:0]            sclData,
  input  logic                         loadEn,
  input  logic [$clog2(NUM_VREGS)-1:0] loadAddr,
  input  logic [VREG_W-1:0]            loadData,
  input  logic [$clog2(NUM_VREGS)-1:0] dbgAddr,
  output logic [VREG_W-1:0]            dbgData
);

  localparam int ADDR_W    = $clog2(NUM_VREGS);
  localparam int NUM_BYTES = VREG_W / 8;
  localparam int BOFF_W    = $clog2(NUM_BYTES);
  localparam int SHIFT_W   = $clog2(VREG_W);
  localparam logic [ADDR_W-1:0] ZERO_REG = ADDR_W'(NUM_VREGS - 1);

  logic [VREG_W-1:0] rfile [NUM_VREGS];
  logic [ADDR_W-1:0] dstQ;
  logic [ADDR_W-1:0] srcQ;
  logic [VREG_W-1:0] oldVecQ;
  logic [SREG_W-1:0] scalarQ;
  logic [SREG_W-1:0] elemMask;
  logic [BOFF_W-1:0] byteOff;
  logic [VREG_W-1:0] placed;
  logic [VREG_W-1:0] laneMask;
  logic [VREG_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstQ    <= '0;
      srcQ    <= '0;
      oldVecQ <= '0;
      scalarQ <= '0;
    end else begin
      if (strobes.latchReq) begin
        dstQ <= reqDst;
        srcQ <= reqSrc;
      end
      if (strobes.readOps) begin
        oldVecQ <= rfile[dstQ];
        scalarQ <= (srcQ == ZERO_REG) ? '0 : sclData;
      end
    end
  end

  assign sclAddr = srcQ;

  // Element value, cut to the decoded width, moved to its lane
  always_comb begin
    case (decInfo.sizeCode)
      2'd0:    elemMask = SREG_W'(8'hFF);
      2'd1:    elemMask = SREG_W'(16'hFFFF);
      2'd2:    elemMask = SREG_W'(32'hFFFF_FFFF);
      default: elemMask = '1;
    endcase
    byteOff = BOFF_W'(decInfo.laneIdx << decInfo.sizeCode);
    placed  = VREG_W'(scalarQ & elemMask) << SHIFT_W'({byteOff, 3'b000});
  end

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byteLane
    logic laneHit;
    assign laneHit = ((BOFF_W'(k) >> decInfo.sizeCode) == decInfo.laneIdx);
    assign laneMask[8*k +: 8] = {8{laneHit}};
    assign merged[8*k +: 8]   = laneHit ? placed[8*k +: 8] : oldVecQ[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      rfile[dstQ] <= merged;
    end else if (loadEn) begin
      rfile[loadAddr] <= loadData;
    end
  end

  assign dbgData = rfile[dbgAddr];

  AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !strobes.commit && !loadEn) |=> (rfile[dstQ] == oldVecQ)); // R1
  AST_LANES_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (((rfile[dstQ] ^ oldVecQ) & ~$past(laneMask)) == '0)); // R4
  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && srcQ == ZERO_REG) |=> ((rfile[dstQ] & $past(laneMask)) == '0)); // R6
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> ($countones(laneMask) == (8 << decInfo.sizeCode))); // R3

endmodule

// File: rtl/vec_insert_unit.sv
module vec_insert_unit
  import vins_pkg::*;
#(
  parameter int NUM_VREGS = 32,
  parameter int VREG_W    = 128,
  parameter int SREG_W    = 64,
  parameter int IMM_W     = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [IMM_W-1:0]             reqImm,
  input  logic [$clog2(NUM_VREGS)-1:0] reqDst,
  input  logic [$clog2(NUM_VREGS)-1:0] reqSrc,
  output logic [$clog2(NUM_VREGS)-1:0] sclAddr,
  input  logic [SREG_W-1:0]            sclData,
  input  logic                         loadEn,
  input  logic [$clog2(NUM_VREGS)-1:0] loadAddr,
  input  logic [VREG_W-1:0]            loadData,
  input  logic [$clog2(NUM_VREGS)-1:0] dbgAddr,
  output logic [VREG_W-1:0]            dbgData,
  output logic                         done,
  output logic                         undef
);

  ctrlStrobes_t strobes;
  decodeInfo_t  decInfo;

  vins_ctrl #(.IMM_W(IMM_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqImm   (reqImm),
    .strobes  (strobes),
    .decInfo  (decInfo),
    .done     (done),
    .undef    (undef)
  );

  vins_datapath #(
    .NUM_VREGS (NUM_VREGS),
    .VREG_W    (VREG_W),
    .SREG_W    (SREG_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .decInfo  (decInfo),
    .reqDst   (reqDst),
    .reqSrc   (reqSrc),
    .sclAddr  (sclAddr),
    .sclData  (sclData),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData)
  );

endmodule

// File: tb/test_vec_insert_unit.sv
module test_vec_insert_unit;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic [4:0]   reqImm, reqDst, reqSrc, sclAddr, loadAddr, dbgAddr;
  logic [63:0]  sclData;
  logic         loadEn;
  logic [127:0] loadData, dbgData;
  logic         done, undef;

  logic [63:0]  sregs [32];
  logic [127:0] model [32];
  int           nTests = 0;
  int           nFail  = 0;

  always #5 clk = ~clk;

  assign sclData = sregs[sclAddr];

  vec_insert_unit i_vec_insert_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqImm(reqImm),
    .reqDst(reqDst), .reqSrc(reqSrc), .sclAddr(sclAddr), .sclData(sclData),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .done(done), .undef(undef)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refMerge(input logic [127:0] old,
                                            input logic [4:0] imm,
                                            input logic [63:0] val);
    int sz = -1;
    int w, idx;
    logic [127:0] r = old;
    for (int i = 3; i >= 0; i--) if (imm[i]) sz = i;
    if (sz < 0) return old;
    w   = 8 << sz;
    idx = int'(imm) >> (sz + 1);
    for (int b = 0; b < 128; b++) if (b / w == idx) r[b] = val[b % w];
    return r;
  endfunction

  task automatic loadVec(input logic [4:0] a, input logic [127:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
    model[a] = d;
  endtask

  task automatic readChk(input string req, input logic [4:0] a);
    dbgAddr = a;
    #1;
    chk(req, dbgData, model[a]);
  endtask

  // Full operation with done/undef timing checks; busy=1 raises a stray request
  task automatic doInsert(input string req, input logic [4:0] imm, input logic [4:0] dst,
                          input logic [4:0] src, input logic busy);
    logic [63:0] v;
    logic        rsv;
    v   = (src == 5'd31) ? 64'd0 : sregs[src];
    rsv = (imm[3:0] == 4'd0);
    @(negedge clk);
    reqValid = 1'b1; reqImm = imm; reqDst = dst; reqSrc = src;
    @(negedge clk);
    chk({req, " R7 done low after accept"}, 128'(done), 128'd0);
    chk({req, " R5 source index"}, 128'(sclAddr), 128'(src));
    if (busy) begin
      reqImm = 5'b00001; reqDst = dst ^ 5'd1; reqSrc = 5'd2;
    end else reqValid = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk({req, " R7 done pulse"}, 128'(done), 128'd1);
    chk({req, " R1 undef"}, 128'(undef), 128'(rsv));
    @(negedge clk);
    chk({req, " R7 done single cycle"}, 128'(done), 128'd0);
    model[dst] = refMerge(model[dst], imm, v);
    readChk({req, " R2 R3 R4 R5 merged entry"}, dst);
    readChk({req, " R4 R8 neighbour entry"}, dst ^ 5'd1);
  endtask

  task automatic testReset();
    chk("R7 done low in reset", 128'(done), 128'd0);
    chk("R1 undef low in reset", 128'(undef), 128'd0);
  endtask

  task automatic testLoad();
    for (int i = 0; i < 32; i++)
      loadVec(5'(i), {4{32'(i * 32'h01010101) ^ 32'hA5C3_1E70}});
    readChk("R9 load entry 0", 5'd0);
    readChk("R9 load entry 31", 5'd31);
    readChk("R9 load entry 17", 5'd17);
  endtask

  task automatic testWidths();
    doInsert("R2 R3 byte lane 0",       5'b00001, 5'd3,  5'd4, 1'b0);
    doInsert("R3 byte lane 15",         5'b11111, 5'd3,  5'd5, 1'b0);
    doInsert("R3 half lane 7",          5'b11110, 5'd6,  5'd4, 1'b0);
    doInsert("R3 half lane 2",          5'b01010, 5'd6,  5'd5, 1'b0);
    doInsert("R3 word lane 2",          5'b10100, 5'd8,  5'd4, 1'b0);
    doInsert("R3 word lane 1",          5'b01100, 5'd8,  5'd6, 1'b0);
    doInsert("R2 dword lane 1",         5'b11000, 5'd10, 5'd5, 1'b0);
    doInsert("R2 dword lane 0",         5'b01000, 5'd10, 5'd6, 1'b0);
  endtask

  task automatic testData();
    loadVec(5'd12, '1);
    doInsert("R5 zeros into ones",      5'b00110, 5'd12, 5'd7, 1'b0);
    loadVec(5'd14, '0);
    doInsert("R5 ones into zeros",      5'b10001, 5'd14, 5'd8, 1'b0);
    doInsert("R4 back to back",         5'b10011, 5'd14, 5'd4, 1'b0);
  endtask

  task automatic testReserved();
    doInsert("R1 reserved 10000",       5'b10000, 5'd16, 5'd4, 1'b0);
    doInsert("R1 reserved 00000",       5'b00000, 5'd16, 5'd5, 1'b0);
  endtask

  task automatic testZeroReg();
    doInsert("R6 zero reg dword",       5'b11000, 5'd18, 5'd31, 1'b0);
    doInsert("R6 zero reg byte",        5'b01011, 5'd18, 5'd31, 1'b0);
  endtask

  task automatic testBusy();
    doInsert("R8 request while busy",   5'b00100, 5'd20, 5'd4, 1'b1);
    @(negedge clk);
    chk("R8 no extra done", 128'(done), 128'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      sregs[i] = {32'(i) * 32'h1357_9BDF, 32'(i) ^ 32'hF00D_BEEF};
    sregs[4]  = 64'h0123_4567_89AB_CDEF;
    sregs[5]  = 64'hFEDC_BA98_7654_3210;
    sregs[7]  = 64'd0;
    sregs[8]  = '1;
    sregs[31] = 64'hDEAD_BEEF_CAFE_F00D;
    rstN = 1'b0; reqValid = 1'b0; reqImm = '0; reqDst = '0; reqSrc = '0;
    loadEn = 1'b0; loadAddr = '0; loadData = '0; dbgAddr = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testLoad();
    testWidths();
    testData();
    testReserved();
    testZeroReg();
    testBusy();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule